// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Selectable Parity

This block turns one parallel data word into an asynchronous serial frame on a single output line. A word is offered on a valid/ready handshake. When the word is taken, the line goes low for one bit time as the start bit. The data bits then follow, least significant bit first. An optional parity bit comes next, and the frame ends with one or two high stop bits. While no frame is in progress, the line stays high.

An internal divider produces one single-cycle bit tick every `BIT_DIV` system clocks. The divider restarts at the moment a word is taken from idle, so the start bit lasts exactly one bit time. The parity mode and the stop-bit count are configuration inputs. They are captured with each word, so a change while a frame is being sent does not alter that frame. If the next word is already waiting during the last cycle of the final stop bit, its start bit follows at once, with no idle bit in between.

Top module: `uart_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `tx_o` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A word is taken only on a clock edge where `in_valid` and `in_ready` are both high. While a frame is in progress, `in_ready` is high in one cycle only: the last cycle of the final stop bit. Words offered at any other time during a frame are ignored.
- R3: Once a word is taken, the start bit drives `tx_o` to 0 for exactly `BIT_DIV` clock cycles, beginning at the edge where the word is taken.
- R4: The `DATA_W` data bits follow the start bit, least significant bit first. Each bit holds for exactly `BIT_DIV` cycles.
- R5: `cfg_parity` uses this encoding: 2'b00 = no parity, 2'b01 = even, 2'b10 = odd, 2'b11 = no parity. With even parity, one extra bit follows the data and makes the count of ones over the data plus that bit even. With odd parity, that count is odd. For data 8'h53, the parity bit is 0 for even and 1 for odd.
- R6: With no parity, the first stop bit follows the last data bit directly.
- R7: `cfg_two_stop` = 0 gives one stop bit and 1 gives two. Each stop bit is high for `BIT_DIV` cycles.
- R8: `busy` is high from the edge where a word is taken until the edge that ends the final stop bit. If no word is waiting at that edge, the block returns to idle.
- R9: If `in_valid` is high in the last cycle of the final stop bit, the next frame's start bit begins at the very next edge, with no idle time between the frames.
- R10: The parity mode and stop count are captured when a word is taken. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block will take a word at this edge |
| in_data | input | DATA_W | Word to send |
| cfg_parity | input | 2 | Parity mode (00 none, 01 even, 10 odd, 11 none) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_o | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is in progress |

## Verification
A wrong state or a miscounted bit index appears on `tx_o` within one bit time: a bit is shifted by one position, a level lasts the wrong number of cycles, or a parity or stop bit is missing. The bench compares the line against the expected frame on every clock. Because of this, an error in a tick count shows up within a single cycle of its bit. A fault in the handshake or the capture logic appears as `in_ready` high in the wrong cycle, or as a frame that changes after the data or configuration inputs are changed during transmission. The back-to-back sequence also shows whether the second start bit begins right at the final stop edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE2 = 2'b11
  } par_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_t;
endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int BIT_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        mode,
  output logic              par_bit,
  output logic              par_on
);
  logic ones_odd;
  assign ones_odd = ^data;

  always_comb begin
    par_bit = 1'b0;
    par_on  = 1'b0;
    case (par_mode_t'(mode))
      PAR_EVEN: begin par_on = 1'b1; par_bit = ones_odd;  end
      PAR_ODD:  begin par_on = 1'b1; par_bit = ~ones_odd; end
      default:  begin par_on = 1'b0; par_bit = 1'b0;      end
    endcase
  end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit ALLOW_B2B = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              par_bit,
  input  logic              par_on,
  input  logic              two_stop,
  output logic              in_ready,
  output logic              take,
  output logic              tx,
  output logic              busy
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  tx_state_t         st;
  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bcnt;
  logic              scnt;
  logic              par_q;
  logic              paron_q;
  logic              two_q;
  logic              txd;
  logic              last_stop;

  assign last_stop = (scnt == two_q);
  assign in_ready  = (st == ST_IDLE) ||
                     (ALLOW_B2B && (st == ST_STOP) && tick && last_stop);
  assign take      = in_valid && in_ready;
  assign tx        = txd;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      txd     <= 1'b1;
      sh      <= '0;
      bcnt    <= '0;
      scnt    <= 1'b0;
      par_q   <= 1'b0;
      paron_q <= 1'b0;
      two_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          txd <= 1'b1;
          if (take) begin
            st      <= ST_START;
            txd     <= 1'b0;
            sh      <= in_data;
            par_q   <= par_bit;
            paron_q <= par_on;
            two_q   <= two_stop;
          end
        end
        ST_START: begin
          if (tick) begin
            st   <= ST_DATA;
            txd  <= sh[0];
            sh   <= sh >> 1;
            bcnt <= '0;
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (bcnt == LAST_BIT) begin
              if (paron_q) begin
                st  <= ST_PARITY;
                txd <= par_q;
              end else begin
                st   <= ST_STOP;
                txd  <= 1'b1;
                scnt <= 1'b0;
              end
            end else begin
              txd  <= sh[0];
              sh   <= sh >> 1;
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_PARITY: begin
          if (tick) begin
            st   <= ST_STOP;
            txd  <= 1'b1;
            scnt <= 1'b0;
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (last_stop) begin
              if (take) begin
                st      <= ST_START;
                txd     <= 1'b0;
                sh      <= in_data;
                par_q   <= par_bit;
                paron_q <= par_on;
                two_q   <= two_stop;
              end else begin
                st  <= ST_IDLE;
                txd <= 1'b1;
              end
            end else begin
              scnt <= 1'b1;
            end
          end
        end
        default: begin
          st  <= ST_IDLE;
          txd <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W    = 8,
  parameter int BIT_DIV   = 16,
  parameter bit ALLOW_B2B = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  output logic              tx_o,
  output logic              busy
);
  logic bit_tick;
  logic take;
  logic restart;
  logic par_bit;
  logic par_on;

  assign restart = take && !busy;

  uart_tx_tick #(.BIT_DIV(BIT_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (bit_tick)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data    (in_data),
    .mode    (cfg_parity),
    .par_bit (par_bit),
    .par_on  (par_on)
  );

  uart_tx_fsm #(.DATA_W(DATA_W), .ALLOW_B2B(ALLOW_B2B)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (bit_tick),
    .in_valid (in_valid),
    .in_data  (in_data),
    .par_bit  (par_bit),
    .par_on   (par_on),
    .two_stop (cfg_two_stop),
    .in_ready (in_ready),
    .take     (take),
    .tx       (tx_o),
    .busy     (busy)
  );
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_o,
  input logic busy,
  input logic in_ready,
  input logic in_valid,
  input logic bit_tick
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tx_o && in_ready)); // R1

  AST_NO_TAKE_MID_FRAME: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |-> !in_ready); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_o); // R3

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |=> $stable(tx_o)); // R4

  AST_READY_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    (busy && in_ready) |-> tx_o); // R7

  AST_B2B_START: assert property (@(posedge clk) disable iff (rst)
    (busy && in_ready && in_valid) |=> (busy && !tx_o)); // R9
endmodule

bind uart_tx uart_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_o     (tx_o),
  .busy     (busy),
  .in_ready (in_ready),
  .in_valid (in_valid),
  .bit_tick (bit_tick)
);

// File: tb/tb_uart_tx.sv
`timescale 1ns/1ps
module tb_uart_tx;
  localparam int DW  = 8;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic [1:0] cfg_parity = 2'b00;
  logic cfg_two_stop = 1'b0;
  logic tx_o;
  logic busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_tx #(.DATA_W(DW), .BIT_DIV(DIV), .ALLOW_B2B(1'b1)) dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .cfg_parity (cfg_parity), .cfg_two_stop (cfg_two_stop),
    .tx_o (tx_o), .busy (busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits(input logic [1:0] pm, input logic two);
    return 1 + DW + (((pm == 2'b01) || (pm == 2'b10)) ? 1 : 0) + (two ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input logic [DW-1:0] d, input logic [1:0] pm,
                                   input logic two, input int k);
    int ones = 0;
    for (int i = 0; i < DW; i++) ones += int'(d[i]);
    if (k == 0) return 1'b0;
    if (k <= DW) return d[k-1];
    if ((k == DW + 1) && (pm == 2'b01)) return logic'(ones % 2);
    if ((k == DW + 1) && (pm == 2'b10)) return logic'(1 - (ones % 2));
    return 1'b1;
  endfunction

  // Called just after the edge that took the word. On the first negedge it
  // applies the next stimulus (valid, data and a changed configuration).
  task automatic check_frame(input logic [DW-1:0] d, input logic [1:0] pm,
                             input logic two, input logic nv,
                             input logic [DW-1:0] nd, input logic [1:0] npm,
                             input logic ntwo);
    int nb = nbits(pm, two);
    for (int k = 0; k < nb; k++) begin
      for (int j = 0; j < DIV; j++) begin
        @(negedge clk);
        if (k == 0) chk("R3 start", tx_o, exp_bit(d, pm, two, k));
        else if (k <= DW) chk("R4 data", tx_o, exp_bit(d, pm, two, k));
        else if (k == DW + 1 && (pm == 2'b01 || pm == 2'b10))
          chk("R5 parity", tx_o, exp_bit(d, pm, two, k));
        else chk("R6/R7 stop", tx_o, exp_bit(d, pm, two, k));
        chk("R8 busy", busy, 1'b1);
        chk("R2 ready", in_ready, (k == nb - 1) && (j == DIV - 1));
        if (k == 0 && j == 0) begin
          in_valid     = nv;
          in_data      = nd;
          cfg_parity   = npm;  // R10: config changed mid-frame
          cfg_two_stop = ntwo;
        end
      end
    end
  endtask

  task automatic send_single(input logic [DW-1:0] d, input logic [1:0] pm,
                             input logic two);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; cfg_parity = pm; cfg_two_stop = two;
    @(posedge clk);
    check_frame(d, pm, two, 1'b0, ~d, ~pm, ~two);
    @(negedge clk);
    chk("R8 idle busy", busy, 1'b0);
    chk("R1 idle line", tx_o, 1'b1);
    chk("R1 idle ready", in_ready, 1'b1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset line", tx_o, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset ready", in_ready, 1'b1);

    // R5: the named example, 8'h53, even then odd parity.
    send_single(8'h53, 2'b01, 1'b0);
    send_single(8'h53, 2'b10, 1'b0);

    // Exhaustive sweep over data, parity mode and stop count.
    for (int two = 0; two < 2; two++)
      for (int pm = 0; pm < 4; pm++)
        for (int d = 0; d < 256; d++)
          send_single(DW'(d), 2'(pm), 1'(two));

    // R9: back-to-back frames, second word waiting during the first frame (R2).
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hA5; cfg_parity = 2'b10; cfg_two_stop = 1'b1;
    @(posedge clk);
    check_frame(8'hA5, 2'b10, 1'b1, 1'b1, 8'h3C, 2'b01, 1'b0);
    @(posedge clk);
    check_frame(8'h3C, 2'b01, 1'b0, 1'b1, 8'hFF, 2'b00, 1'b1);
    @(posedge clk);
    check_frame(8'hFF, 2'b00, 1'b1, 1'b0, 8'h00, 2'b11, 1'b0);
    @(negedge clk);
    chk("R9 end idle", busy, 1'b0);
    chk("R1 end line", tx_o, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule